// File: doc/BRIEF.md
# PCI Bridge Control Register Bank

This block is the programmed-I/O register bank of a host-to-PCI bridge. It decodes 64-bit accesses into a 4 KB region and keeps the bridge's address-window setup: four window base values, four window mask values, four translated-base values and one bridge control word. All of them are driven straight out on ports for the translation logic that sits beside it. Any location that needs no storage has fixed behaviour. Some read as zero and quietly take writes. Others reject the access with an error response.

Each register sits in its own 64-byte slot. The register index is the byte offset shifted right by six, so the low six address bits do not affect which register is selected. A request is presented for one cycle with `req_valid`. The response, with `rsp_valid`, an error flag and the read data, appears exactly one cycle later. A write takes effect at the same clock edge that captures the response.

Top module: `pcib_regbank`

## Requirements
- R1: After reset, all window base, window mask and translated-base registers are zero, the control register is 0x0000_0021_0010_0000 (bits 20, 32 and 37 set), and `rsp_valid` is low.
- R2: Indices 0-3 hold window bases 0-3, 4-7 hold window masks 0-3 and 8-11 hold translated bases 0-3. All are fully read/write with no error. The matching export port shows a written value from the cycle after the write.
- R3: Index 12 is the control register. It is fully read/write and is driven on `ctrl_o`.
- R4: Every request gets exactly one response, with `rsp_valid` high in the cycle after the request. `rsp_valid` is low in any cycle that follows a cycle with no request.
- R5: Only `req_size` = 3 (8 bytes) is legal. Any other size code gives an error and leaves all registers unchanged.
- R6: A byte offset of 0x1000 or above gives an error and leaves all registers unchanged.
- R7: Index 13 (error status) reads zero without error. A write to it succeeds and changes no register.
- R8: Index 14 (error mask) reads zero without error. A write to it gives an error.
- R9: Index 15 (TLB invalidate-all) reads zero without error. A write to it succeeds and changes no register.
- R10: Indices 16-21 (latency, reserved, error set, TLB invalidate-virtual, monitor control, monitor count) and every index from 22 to 63 give an error on both read and write, and a write there changes no register.
- R11: `rsp_rdata` is zero whenever `rsp_err` is set, and in every write response.
- R12: Address bits 5:0 do not affect register selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte offset from the region base |
| req_size | input | 2 | Access size code; 3 = 8 bytes |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 64 | Read data, zero on error or write |
| win_base_o | output | 256 | Window bases, window n at bits 64n+63:64n |
| win_mask_o | output | 256 | Window masks, same packing |
| xlat_base_o | output | 256 | Translated bases, same packing |
| ctrl_o | output | 64 | Bridge control register |

## Verification
A wrong decode would either send a write to the wrong slot or let it land when it should not. That shows on the export ports in the very next cycle, and on `rsp_rdata` at the next read of the affected register. A wrong error classification shows on `rsp_err` in the response cycle of the access itself. Because of that, every access is checked for error and data, and all exports are compared with a model after every access. A fault therefore appears within one access of its cause.

// File: rtl/pcib_pkg.sv
package pcib_pkg;

  typedef enum logic [2:0] {
    K_WBASE, K_WMASK, K_XBASE, K_CTRL, K_ESTAT, K_EMASK, K_TLBIA, K_BAD
  } kind_e;

  localparam logic [63:0] CTRL_RESET = 64'h0000_0021_0010_0000;
  localparam logic [1:0]  SIZE_DW    = 2'd3;

  // Map a slot index onto its register class; fixed locations follow the
  // three window groups and the control word.
  function automatic kind_e kind_of(int unsigned idx, int unsigned nwin);
    if (idx < nwin)                 return K_WBASE;
    else if (idx < 2 * nwin)        return K_WMASK;
    else if (idx < 3 * nwin)        return K_XBASE;
    else if (idx == 3 * nwin)       return K_CTRL;
    else if (idx == 3 * nwin + 1)   return K_ESTAT;
    else if (idx == 3 * nwin + 2)   return K_EMASK;
    else if (idx == 3 * nwin + 3)   return K_TLBIA;
    else                            return K_BAD;
  endfunction

  // Window number within a group.
  function automatic int unsigned win_of(int unsigned idx, int unsigned nwin);
    return idx % nwin;
  endfunction

endpackage

// File: rtl/pcib_decode.sv
module pcib_decode
  import pcib_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int NWIN         = 4,
  parameter int REGION_BYTES = 4096,
  parameter int SLOT_SHIFT   = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_we,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [1:0]                req_size,
  output kind_e                     kind,
  output logic [$clog2(NWIN)-1:0]   win_sel,
  output logic                      acc_err,
  output logic                      wr_en
);
  localparam int IDX_W = ADDR_W - SLOT_SHIFT;

  logic in_region;
  logic size_ok;
  logic [IDX_W-1:0] slot_idx;

  always_comb begin
    in_region = (int'(req_addr) < REGION_BYTES);
    size_ok   = (req_size == SIZE_DW);
    slot_idx  = req_addr[ADDR_W-1:SLOT_SHIFT];
    kind      = kind_of(int'(slot_idx), NWIN);
    win_sel   = win_of(int'(slot_idx), NWIN) % (1 << $clog2(NWIN));
    acc_err   = !in_region || !size_ok || (kind == K_BAD) ||
                (req_we && kind == K_EMASK);
    wr_en     = req_valid && req_we && !acc_err &&
                (kind inside {K_WBASE, K_WMASK, K_XBASE, K_CTRL});
  end

  AST_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != 2'd3) |-> acc_err && !wr_en); // R5

  AST_REGION_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && int'(req_addr) >= REGION_BYTES) |-> !wr_en); // R6

endmodule

// File: rtl/pcib_regfile.sv
module pcib_regfile
  import pcib_pkg::*;
#(
  parameter int NWIN = 4,
  parameter int DW   = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  kind_e                    kind,
  input  logic [$clog2(NWIN)-1:0]  win_sel,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rd_data,
  output logic [NWIN*DW-1:0]       win_base_o,
  output logic [NWIN*DW-1:0]       win_mask_o,
  output logic [NWIN*DW-1:0]       xlat_base_o,
  output logic [DW-1:0]            ctrl_o
);
  logic [DW-1:0] wbase [NWIN];
  logic [DW-1:0] wmask [NWIN];
  logic [DW-1:0] xbase [NWIN];
  logic [DW-1:0] ctrl_q;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wbase[g] <= '0;
        wmask[g] <= '0;
        xbase[g] <= '0;
      end else if (wr_en && int'(win_sel) == g) begin
        if (kind == K_WBASE) wbase[g] <= wdata;
        if (kind == K_WMASK) wmask[g] <= wdata;
        if (kind == K_XBASE) xbase[g] <= wdata;
      end
    end
    assign win_base_o[g*DW +: DW]  = wbase[g];
    assign win_mask_o[g*DW +: DW]  = wmask[g];
    assign xlat_base_o[g*DW +: DW] = xbase[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        ctrl_q <= CTRL_RESET[DW-1:0];
    else if (wr_en && kind == K_CTRL)  ctrl_q <= wdata;
  end
  assign ctrl_o = ctrl_q;

  always_comb begin
    unique case (kind)
      K_WBASE: rd_data = wbase[win_sel];
      K_WMASK: rd_data = wmask[win_sel];
      K_XBASE: rd_data = xbase[win_sel];
      K_CTRL:  rd_data = ctrl_q;
      default: rd_data = '0;
    endcase
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q)); // R3

  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(win_base_o) && $stable(win_mask_o) && $stable(xlat_base_o)); // R2

endmodule

// File: rtl/pcib_regbank.sv
module pcib_regbank
  import pcib_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int NWIN         = 4,
  parameter int DW           = 64,
  parameter int REGION_BYTES = 4096,
  parameter int SLOT_SHIFT   = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_we,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_size,
  input  logic [DW-1:0]        req_wdata,
  output logic                 rsp_valid,
  output logic                 rsp_err,
  output logic [DW-1:0]        rsp_rdata,
  output logic [NWIN*DW-1:0]   win_base_o,
  output logic [NWIN*DW-1:0]   win_mask_o,
  output logic [NWIN*DW-1:0]   xlat_base_o,
  output logic [DW-1:0]        ctrl_o
);
  kind_e                    dec_kind;
  logic [$clog2(NWIN)-1:0]  dec_win;
  logic                     dec_err;
  logic                     dec_wr;
  logic [DW-1:0]            rf_rd;

  pcib_decode #(
    .ADDR_W(ADDR_W), .NWIN(NWIN),
    .REGION_BYTES(REGION_BYTES), .SLOT_SHIFT(SLOT_SHIFT)
  ) u_dec (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_size(req_size),
    .kind(dec_kind), .win_sel(dec_win),
    .acc_err(dec_err), .wr_en(dec_wr)
  );

  pcib_regfile #(.NWIN(NWIN), .DW(DW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(dec_wr), .kind(dec_kind), .win_sel(dec_win),
    .wdata(req_wdata), .rd_data(rf_rd),
    .win_base_o(win_base_o), .win_mask_o(win_mask_o),
    .xlat_base_o(xlat_base_o), .ctrl_o(ctrl_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && dec_err;
      rsp_rdata <= (req_valid && !req_we && !dec_err) ? rf_rd : '0;
    end
  end

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R4

  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> rsp_rdata == '0); // R11

  AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid); // R4

  AST_WRITE_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we) |=> rsp_rdata == '0); // R11

endmodule

// File: tb/pcib_regbank_test.sv
module pcib_regbank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_we;
  logic [15:0] req_addr;
  logic [1:0]  req_size;
  logic [63:0] req_wdata;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic [255:0] win_base_o, win_mask_o, xlat_base_o;
  logic [63:0] ctrl_o;

  int checks = 0;
  int errors = 0;

  logic [63:0] mb [4];
  logic [63:0] mm [4];
  logic [63:0] mx [4];
  logic [63:0] mc;

  always #5 clk = ~clk;

  pcib_regbank uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .win_base_o(win_base_o), .win_mask_o(win_mask_o),
    .xlat_base_o(xlat_base_o), .ctrl_o(ctrl_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Model of one access: expected error flag, expected data, state update.
  task automatic model(input logic we, input logic [15:0] a, input logic [1:0] sz,
                       input logic [63:0] wd, output logic e, output logic [63:0] d);
    int i;
    i = int'(a) / 64;
    e = 1'b0;
    d = 64'h0;
    if (a >= 16'h1000 || sz != 2'd3) e = 1'b1;
    else if (i <= 3)  begin if (we) mb[i] = wd;      else d = mb[i]; end
    else if (i <= 7)  begin if (we) mm[i-4] = wd;    else d = mm[i-4]; end
    else if (i <= 11) begin if (we) mx[i-8] = wd;    else d = mx[i-8]; end
    else if (i == 12) begin if (we) mc = wd;         else d = mc; end
    else if (i == 13 || i == 15) d = 64'h0;
    else if (i == 14) e = we;
    else e = 1'b1;
  endtask

  task automatic cmp_exports(input string tag);
    for (int w = 0; w < 4; w++) begin
      chk({tag, " base"}, win_base_o[w*64 +: 64], mb[w]);
      chk({tag, " mask"}, win_mask_o[w*64 +: 64], mm[w]);
      chk({tag, " xlat"}, xlat_base_o[w*64 +: 64], mx[w]);
    end
    chk({tag, " ctrl"}, ctrl_o, mc);
  endtask

  task automatic access(input string tag, input logic we, input logic [15:0] a,
                        input logic [1:0] sz, input logic [63:0] wd);
    logic e;
    logic [63:0] d;
    model(we, a, sz, wd, e, d);
    req_valid = 1'b1; req_we = we; req_addr = a; req_size = sz; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid R4"}, {63'h0, rsp_valid}, 64'h1);
    chk({tag, " err"}, {63'h0, rsp_err}, {63'h0, e});
    chk({tag, " data R11"}, rsp_rdata, d);
    cmp_exports(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0;
    req_addr = '0; req_size = 2'd3; req_wdata = '0;
    for (int w = 0; w < 4; w++) begin mb[w] = 0; mm[w] = 0; mx[w] = 0; end
    mc = 64'h0000_0021_0010_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", {63'h0, rsp_valid}, 64'h0);
    cmp_exports("R1");
    access("R1 ctrl read", 1'b0, 16'h0300, 2'd3, 0);

    // R2 each window register, written and read back
    for (int i = 0; i < 12; i++) begin
      access("R2 write", 1'b1, 16'(i * 64), 2'd3, {32'hA5A5_0000 + i, 32'h1234_5678 ^ i});
      access("R2 read", 1'b0, 16'(i * 64), 2'd3, 0);
    end
    // R3 control
    access("R3 write", 1'b1, 16'h0300, 2'd3, 64'hDEAD_BEEF_0BAD_F00D);
    access("R3 read", 1'b0, 16'h0300, 2'd3, 0);
    // R4 no request -> no response
    @(negedge clk);
    chk("R4 idle", {63'h0, rsp_valid}, 64'h0);
    // R5 illegal sizes
    for (int s = 0; s < 3; s++) access("R5 size", 1'b1, 16'h0040, 2'(s), 64'h1111);
    access("R5 size read", 1'b0, 16'h0040, 2'd1, 0);
    // R6 outside region
    access("R6 edge", 1'b1, 16'h1000, 2'd3, 64'h2222);
    access("R6 far", 1'b0, 16'hFFC0, 2'd3, 0);
    access("R6 last ok", 1'b0, 16'h0FFF, 2'd3, 0);
    // R7 error status
    access("R7 write", 1'b1, 16'h0340, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    access("R7 read", 1'b0, 16'h0340, 2'd3, 0);
    // R8 error mask
    access("R8 read", 1'b0, 16'h0380, 2'd3, 0);
    access("R8 write", 1'b1, 16'h0380, 2'd3, 64'h5);
    // R9 TLB invalidate-all
    access("R9 write", 1'b1, 16'h03C0, 2'd3, 64'h7);
    access("R9 read", 1'b0, 16'h03C0, 2'd3, 0);
    // R10 unsupported and unknown indices
    for (int i = 16; i < 64; i += 3) begin
      access("R10 write", 1'b1, 16'(i * 64), 2'd3, 64'h3333);
      access("R10 read", 1'b0, 16'(i * 64), 2'd3, 0);
    end
    // R12 low offset bits ignored
    access("R12 write", 1'b1, 16'h0127, 2'd3, 64'h0123_4567_89AB_CDEF);
    access("R12 read", 1'b0, 16'h0139, 2'd3, 0);
    access("R12 ctrl", 1'b0, 16'h033F, 2'd3, 0);

    // random mix (R2 R5 R6 R10 R11)
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      logic [1:0] sz;
      a  = 16'($urandom_range(0, 16'h13FF));
      if (($urandom & 3) == 0) a = 16'($urandom_range(0, 16'h033F));
      sz = (($urandom & 7) == 0) ? 2'($urandom) : 2'd3;
      access("R2 random", 1'($urandom), a, sz, {$urandom, $urandom});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule